// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block sits in the master clock domain of an audio converter and works out, once per reset, how many master clock cycles make up one frame (left/right) clock period. The frame clock runs at the sample rate and is already synchronous to the master clock. No particular phase between the two is assumed.

After reset is released, the block waits for a genuine rising edge of the frame clock. It then counts master clock cycles up to the next rising edge and matches that count against the ratios allowed for the configured speed range. A match raises a lock flag and publishes two values: a per-mode ratio code and a divider select for the internal sample-clock dividers. Any other outcome raises an error flag instead. These outcomes are a count that fits no allowed ratio, a reserved speed setting, or a frame clock that never produces a second edge. The result stays fixed until the next reset.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `locked` and `err` are 0 and `ratio_code` and `div_sel` are 0. Whenever neither flag is set, `ratio_code` and `div_sel` remain 0.
- R2: The measured count N is the number of master clock rising edges from the first sampled frame clock rise after reset to the next one. A frame clock that is already high when reset is released does not count as a rise. The flags update at the same master clock edge that samples the second rise, and `locked` and `err` are never both 1.
- R3: With `speed_sel` = 0 (single rate), N = 256, 384, 512 and 768 lock with `ratio_code` 0, 1, 2 and 3.
- R4: With `speed_sel` = 1 (double rate), N = 128, 192, 256 and 384 lock with `ratio_code` 0, 1, 2 and 3.
- R5: With `speed_sel` = 2 (quad rate), N = 64, 96, 128 and 192 lock with `ratio_code` 0, 1, 2 and 3.
- R6: The fifth ratio of each mode is 1024 for single rate, 512 for double rate and 256 for quad rate. It locks with `ratio_code` 4 only when `div_en` is 1. With `div_en` at 0, that count sets `err`.
- R7: A count within ±1 of an allowed ratio locks as that ratio. A count two or more away from every allowed ratio sets `err`.
- R8: If no second rise has arrived when the 11-bit counter reaches 2047, `err` is set at that edge, 2047 cycles after the first rise.
- R9: Once `locked` or `err` is set, it and `ratio_code`/`div_sel` hold their values until reset, whatever the frame clock does afterwards.
- R10: `speed_sel` and `div_en` are taken in while reset is low. Changes to them after reset is released have no effect on the result.
- R11: `div_sel` indexes the combined ratio list 64, 96, 128, 192, 256, 384, 512, 768, 1024 as 0 to 8. It equals `ratio_code` plus 4 (single), 2 (double) or 0 (quad).
- R12: `speed_sel` = 3 is reserved. Any completed measurement then sets `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset; also the window in which configuration is taken in |
| frame_clk | input | 1 | Frame (left/right) clock, synchronous to `clk_mst` |
| speed_sel | input | 2 | Speed range: 0 single, 1 double, 2 quad, 3 reserved |
| div_en | input | 1 | Admits the fifth, largest ratio of the mode |
| ratio_code | output | 3 | Index 0-4 of the matched ratio within the mode |
| div_sel | output | 4 | Index 0-8 of the matched ratio in the combined list |
| locked | output | 1 | Ratio identified |
| err | output | 1 | Measurement failed or ratio not allowed |

## Verification
Several internal faults can be told apart at the ports by when and how they show. An off-by-one in the counter start or edge detector shifts N. That turns the ±2 boundary counts into locks, or the ±1 counts into errors, at exactly the cycle of the second rise. A detector that takes the level at reset release as an edge measures a shortened first period and flags the wrong ratio. A state machine that re-arms shows as `ratio_code` changing one period later. Configuration that is not held shows the moment the inputs move after reset. The bench's reference model compares all four outputs on every cycle, so each of these appears on the cycle it occurs rather than at the end of a test.

// File: rtl/mrd_pkg.sv
// Package: shared constants, types and the ratio table function for the
// master clock ratio detector. Assumes speed code 3 is reserved.
package mrd_pkg;

    localparam int MRD_CNT_W      = 11;
    localparam int MRD_NUM_RATIOS = 5;
    localparam int MRD_CODE_W     = 3;
    localparam int MRD_DIV_W      = 4;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2,
        SPD_RSVD   = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        MS_ARM   = 2'd0,
        MS_COUNT = 2'd1,
        MS_DONE  = 2'd2
    } meas_state_e;

    // Nominal master/frame ratio for a speed mode and a position 0..4 in its list.
    function automatic int nominal_ratio(input logic [1:0] mode, input int idx);
        int twice_mult;
        case (idx)
            0:       twice_mult = 2;
            1:       twice_mult = 3;
            2:       twice_mult = 4;
            3:       twice_mult = 6;
            default: twice_mult = 8;
        endcase
        return (128 >> mode) * twice_mult;
    endfunction

endpackage

// File: rtl/mrd_cfg_capture.sv
// Configuration capture: takes the speed range and divide enable while reset
// is low and holds them once reset is released.
// Assumes the inputs are settled during reset.
module mrd_cfg_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_in,
    input  logic       div_en_in,
    output logic [1:0] speed_q,
    output logic       div_en_q
);

    // Load while in reset, freeze otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_q  <= speed_in;
            div_en_q <= div_en_in;
        end
    end

endmodule

// File: rtl/mrd_measure.sv
// Period measurement: arms after reset, starts counting at the first sampled
// rise of the frame clock and stops at the next rise or at counter saturation.
// Emits a one-cycle pulse for each outcome and then stays idle until reset.
// Assumes frame_clk is synchronous to clk.
module mrd_measure #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_clk,
    output logic             meas_done,
    output logic             meas_sat,
    output logic [CNT_W-1:0] count
);
    import mrd_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    meas_state_e state;
    logic        fc_q;
    logic        rise;

    assign rise      = frame_clk & ~fc_q;
    assign meas_done = (state == MS_COUNT) && rise;
    assign meas_sat  = (state == MS_COUNT) && !rise && (count == CNT_MAX);

    // Previous frame clock level; reset high so a level held through reset is no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) fc_q <= 1'b1;
        else        fc_q <= frame_clk;
    end

    // Measurement sequencing and saturating cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MS_ARM;
            count <= '0;
        end else begin
            case (state)
                MS_ARM: begin
                    if (rise) begin
                        state <= MS_COUNT;
                        count <= CNT_W'(1);
                    end
                end
                MS_COUNT: begin
                    if (rise || count == CNT_MAX) state <= MS_DONE;
                    else                          count <= count + 1'b1;
                end
                default: state <= MS_DONE;
            endcase
        end
    end

endmodule

// File: rtl/mrd_classify.sv
// Ratio classifier: compares a cycle count with each allowed ratio of the
// configured speed range within a +/-TOL window and returns the lowest match.
// Assumes allowed ratios are further apart than 2*TOL+1.
module mrd_classify #(
    parameter int CNT_W = 11,
    parameter int TOL   = 1
) (
    input  logic [1:0]                        mode,
    input  logic                              div_en,
    input  logic [CNT_W-1:0]                  count,
    output logic                              hit,
    output logic [mrd_pkg::MRD_CODE_W-1:0]    code,
    output logic [mrd_pkg::MRD_DIV_W-1:0]     div_idx
);
    import mrd_pkg::*;

    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0]          cnt_ext;
    logic [SUM_W-1:0]          nom [MRD_NUM_RATIOS];
    logic [MRD_NUM_RATIOS-1:0] match;
    logic [MRD_DIV_W-1:0]      offset;

    assign cnt_ext = {1'b0, count};

    for (genvar g = 0; g < MRD_NUM_RATIOS; g++) begin : g_cand
        logic allowed;
        assign nom[g]   = SUM_W'(nominal_ratio(mode, g));
        assign allowed  = (mode != SPD_RSVD) && ((g < MRD_NUM_RATIOS - 1) || div_en);
        assign match[g] = allowed
                        && (cnt_ext >= nom[g] - SUM_W'(TOL))
                        && (cnt_ext <= nom[g] + SUM_W'(TOL));
    end

    // Priority pick of the lowest matching position.
    always_comb begin
        hit  = 1'b0;
        code = '0;
        for (int k = MRD_NUM_RATIOS - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit  = 1'b1;
                code = MRD_CODE_W'(k);
            end
        end
    end

    // Offset of the mode's first ratio within the combined list.
    always_comb begin
        case (mode)
            SPD_SINGLE: offset = MRD_DIV_W'(4);
            SPD_DOUBLE: offset = MRD_DIV_W'(2);
            default:    offset = '0;
        endcase
    end

    assign div_idx = MRD_DIV_W'(code) + offset;

endmodule

// File: rtl/mclk_ratio_detect.sv
// Top: master clock ratio detector. Measures one frame clock period in
// master clock cycles after reset and registers a locked result or an error.
// Assumes frame_clk is synchronous to clk_mst and configuration is set in reset.
module mclk_ratio_detect #(
    parameter int CNT_W = mrd_pkg::MRD_CNT_W,
    parameter int TOL   = 1
) (
    input  logic                           clk_mst,
    input  logic                           rst_n,
    input  logic                           frame_clk,
    input  logic [1:0]                     speed_sel,
    input  logic                           div_en,
    output logic [mrd_pkg::MRD_CODE_W-1:0] ratio_code,
    output logic [mrd_pkg::MRD_DIV_W-1:0]  div_sel,
    output logic                           locked,
    output logic                           err
);
    import mrd_pkg::*;

    logic [1:0]            cfg_mode;
    logic                  cfg_div_en;
    logic                  meas_done;
    logic                  meas_sat;
    logic [CNT_W-1:0]      count;
    logic                  cls_hit;
    logic [MRD_CODE_W-1:0] cls_code;
    logic [MRD_DIV_W-1:0]  cls_div;

    mrd_cfg_capture u_cfg (
        .clk       (clk_mst),
        .rst_n     (rst_n),
        .speed_in  (speed_sel),
        .div_en_in (div_en),
        .speed_q   (cfg_mode),
        .div_en_q  (cfg_div_en)
    );

    mrd_measure #(.CNT_W(CNT_W)) u_meas (
        .clk       (clk_mst),
        .rst_n     (rst_n),
        .frame_clk (frame_clk),
        .meas_done (meas_done),
        .meas_sat  (meas_sat),
        .count     (count)
    );

    mrd_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
        .mode    (cfg_mode),
        .div_en  (cfg_div_en),
        .count   (count),
        .hit     (cls_hit),
        .code    (cls_code),
        .div_idx (cls_div)
    );

    // Result registers: written once per reset by the measurement outcome.
    always_ff @(posedge clk_mst) begin
        if (!rst_n) begin
            locked     <= 1'b0;
            err        <= 1'b0;
            ratio_code <= '0;
            div_sel    <= '0;
        end else if (meas_done) begin
            if (cls_hit) begin
                locked     <= 1'b1;
                ratio_code <= cls_code;
                div_sel    <= cls_div;
            end else begin
                err <= 1'b1;
            end
        end else if (meas_sat) begin
            err <= 1'b1;
        end
    end

endmodule

// File: rtl/mrd_checker.sv
// Checker: temporal properties of the ratio detector outputs, bound to the top.
module mrd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ratio_code,
    input logic [3:0] div_sel,
    input logic       locked,
    input logic       err,
    input logic [1:0] cfg_mode,
    input logic       cfg_div_en
);

    // R2: lock and error are exclusive.
    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && err));

    // R9: a lock and its result persist.
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(ratio_code) && $stable(div_sel)));

    // R9: an error persists.
    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R6: the fifth ratio needs the captured divide enable.
    p_top_ratio_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && ratio_code == 3'd4) |-> cfg_div_en);

    // R3: code stays within the five positions.
    p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (ratio_code <= 3'd4));

    // R12: reserved mode never locks.
    p_rsvd_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3) |-> !locked);

    // R1: result fields idle at zero until a flag is set.
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !err) |-> (ratio_code == 3'd0 && div_sel == 4'd0));

    // R11: divider select never leaves the combined list.
    p_div_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (div_sel <= 4'd8));

endmodule

bind mclk_ratio_detect mrd_checker u_chk (
    .clk        (clk_mst),
    .rst_n      (rst_n),
    .ratio_code (ratio_code),
    .div_sel    (div_sel),
    .locked     (locked),
    .err        (err),
    .cfg_mode   (cfg_mode),
    .cfg_div_en (cfg_div_en)
);

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic [1:0] speed_sel = 2'd0;
    logic       div_en = 1'b0;
    logic [2:0] ratio_code;
    logic [3:0] div_sel;
    logic       locked;
    logic       err;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string cur_tag = "R1";

    // Reference model state
    int m_state = 0;
    int m_cnt   = 0;
    bit m_prev  = 1'b1;
    int m_mode  = 0;
    bit m_div   = 1'b0;
    bit e_lock  = 1'b0;
    bit e_err   = 1'b0;
    int e_code  = 0;
    int e_div   = 0;

    always #5 clk = ~clk;

    mclk_ratio_detect u_dut (
        .clk_mst    (clk),
        .rst_n      (rst_n),
        .frame_clk  (frame_clk),
        .speed_sel  (speed_sel),
        .div_en     (div_en),
        .ratio_code (ratio_code),
        .div_sel    (div_sel),
        .locked     (locked),
        .err        (err)
    );

    task automatic model_classify();
        int base_list[5] = '{256, 384, 512, 768, 1024};
        bit found = 1'b0;
        if (m_mode != 3) begin
            for (int k = 0; k < 5; k++) begin
                int r;
                r = base_list[k] >> m_mode;
                if (k == 4 && !m_div) continue;
                if (!found && m_cnt >= r - 1 && m_cnt <= r + 1) begin
                    found  = 1'b1;
                    e_lock = 1'b1;
                    e_code = k;
                    e_div  = k + 4 - 2 * m_mode;
                end
            end
        end
        if (!found) e_err = 1'b1;
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit rise;
        cycles++;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_prev = 1'b1;
            m_mode = int'(speed_sel); m_div = div_en;
            e_lock = 0; e_err = 0; e_code = 0; e_div = 0;
        end else begin
            rise = frame_clk && !m_prev;
            if (m_state == 0) begin
                if (rise) begin m_state = 1; m_cnt = 1; end
            end else if (m_state == 1) begin
                if (rise) begin model_classify(); m_state = 2; end
                else if (m_cnt >= 2047) begin e_err = 1'b1; m_state = 2; end
                else m_cnt++;
            end
            m_prev = frame_clk;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        n_checks++;
        if (locked !== e_lock || err !== e_err ||
            int'(ratio_code) != e_code || int'(div_sel) != e_div) begin
            n_fail++;
            $display("FAIL %s model cycle %0d: act lock=%0b err=%0b code=%0d div=%0d exp lock=%0b err=%0b code=%0d div=%0d",
                     cur_tag, cycles, locked, err, ratio_code, div_sel, e_lock, e_err, e_code, e_div);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 190000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: act cycles=%0d exp below 190000", cycles);
            finish_run();
        end
    end

    task automatic check_res(input string tag, input bit x_lock, input bit x_err,
                             input int x_code, input int x_div);
        n_checks++;
        if (locked !== x_lock || err !== x_err ||
            int'(ratio_code) != x_code || int'(div_sel) != x_div) begin
            n_fail++;
            $display("FAIL %s: act lock=%0b err=%0b code=%0d div=%0d exp lock=%0b err=%0b code=%0d div=%0d",
                     tag, locked, err, ratio_code, div_sel, x_lock, x_err, x_code, x_div);
        end
    endtask

    task automatic do_reset(input logic [1:0] m, input logic d, input logic fc);
        @(negedge clk);
        rst_n = 1'b0; speed_sel = m; div_en = d; frame_clk = fc;
        repeat (4) @(negedge clk);
        check_res("R1 in reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_res("R1 after release", 0, 0, 0, 0);
    endtask

    task automatic frames(input int period, input int n);
        for (int p = 0; p < n; p++) begin
            for (int i = 0; i < period; i++) begin
                frame_clk = (i < period / 2);
                @(negedge clk);
            end
        end
    endtask

    task automatic run_case(input string tag, input logic [1:0] m, input logic d,
                            input int period, input bit x_lock, input bit x_err,
                            input int x_code, input int x_div);
        cur_tag = tag;
        do_reset(m, d, 1'b0);
        frames(period, 3);
        check_res(tag, x_lock, x_err, x_code, x_div);
    endtask

    initial begin
        cur_tag = "R1";
        do_reset(2'd0, 1'b0, 1'b0);

        run_case("R3 single 256 (R11 div 4)", 2'd0, 1'b0, 256, 1, 0, 0, 4);
        run_case("R3 single 384",            2'd0, 1'b0, 384, 1, 0, 1, 5);
        run_case("R3 single 768 (R11 div 7)", 2'd0, 1'b0, 768, 1, 0, 3, 7);
        run_case("R6 single 1024 div_en=1",  2'd0, 1'b1, 1024, 1, 0, 4, 8);
        run_case("R6 single 1024 div_en=0",  2'd0, 1'b0, 1024, 0, 1, 0, 0);
        run_case("R4 double 128 (R11 div 2)", 2'd1, 1'b0, 128, 1, 0, 0, 2);
        run_case("R4 double 256",            2'd1, 1'b1, 256, 1, 0, 2, 4);
        run_case("R6 double 512 div_en=1",   2'd1, 1'b1, 512, 1, 0, 4, 6);
        run_case("R5 quad 64 (R11 div 0)",   2'd2, 1'b0, 64, 1, 0, 0, 0);
        run_case("R5 quad 96",               2'd2, 1'b0, 96, 1, 0, 1, 1);
        run_case("R5 quad 192",              2'd2, 1'b0, 192, 1, 0, 3, 3);
        run_case("R6 quad 256 div_en=1",     2'd2, 1'b1, 256, 1, 0, 4, 4);
        run_case("R6 quad 256 div_en=0",     2'd2, 1'b0, 256, 0, 1, 0, 0);
        run_case("R7 single 383 low edge",   2'd0, 1'b0, 383, 1, 0, 1, 5);
        run_case("R7 single 385 high edge",  2'd0, 1'b0, 385, 1, 0, 1, 5);
        run_case("R7 single 386 outside",    2'd0, 1'b0, 386, 0, 1, 0, 0);
        run_case("R7 quad 62 outside",       2'd2, 1'b0, 62, 0, 1, 0, 0);
        run_case("R12 reserved mode 256",    2'd3, 1'b1, 256, 0, 1, 0, 0);

        // R8: one rise, then frame clock stuck high until saturation.
        cur_tag = "R8 saturation";
        do_reset(2'd0, 1'b0, 1'b0);
        frame_clk = 1'b1;
        repeat (2045) @(negedge clk);
        check_res("R8 before saturation", 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        check_res("R8 after saturation", 0, 1, 0, 0);

        // R9: locked at quad 192, later shorter periods ignored.
        cur_tag = "R9 hold";
        do_reset(2'd2, 1'b0, 1'b0);
        frames(192, 2);
        frames(128, 4);
        check_res("R9 result held after new period", 1, 0, 3, 3);

        // R10: configuration moved after reset release is ignored.
        cur_tag = "R10 cfg";
        do_reset(2'd0, 1'b0, 1'b0);
        speed_sel = 2'd2; div_en = 1'b1;
        frames(256, 3);
        check_res("R10 single kept though inputs show quad", 1, 0, 0, 4);

        // R2: frame clock high through reset release is not a rise.
        cur_tag = "R2 level at release";
        do_reset(2'd1, 1'b0, 1'b1);
        repeat (100) @(negedge clk);
        check_res("R2 no rise seen while level held", 0, 0, 0, 0);
        frames(192, 3);
        check_res("R2 measured from first genuine rise", 1, 0, 1, 3);

        finish_run();
    end

endmodule